// File: doc/BRIEF.md
# Mirrored Palette Index Memory

This block holds the palette of a video controller. It has 32 entries, and each entry keeps a 6-bit pointer into a 64-colour master table. Entries 0 to 15 serve background tiles and entries 16 to 31 serve sprites. Entry 0 is the shared backdrop colour, which shows wherever a pixel is transparent. Every other index whose two low bits are zero is not a storage location of its own: it reaches entry 0 for both reads and writes.

The processor side reaches the block through the video address pointer. Only the five low bits of that pointer select an entry, so the 32 entries repeat across the whole palette window. A write lands on the next rising clock edge and keeps only the six low data bits. A read returns the stored value combinationally, with the two upper data bits at zero.

The render side is a valid/ready stream. A pixel's 5-bit palette index goes in, and its 6-bit colour index comes out in the same cycle. The block holds no data on this path. The output valid follows the input valid, and the input ready follows the output ready. Under back-pressure the producer must therefore keep its index stable, and the colour stays stable with it.

Top module: `pal_index_mem`

## Requirements
- R1: While rst_n is low at a rising edge, every entry is cleared to 0. After reset, every index reads 0 on both ports.
- R2: A write stores only bits 5:0 of cpu_wdata_i and discards bits 7:6. cpu_rdata_o always carries 0 in bits 7:6.
- R3: Only cpu_addr_i[4:0] selects an entry. Two addresses that differ only above bit 4 reach the same entry.
- R4: Any CPU index whose bits 1:0 are 00 (0, 4, 8, 12, 16, 20, 24, 28) reaches entry 0. A read there returns entry 0, and a write there updates entry 0.
- R5: cpu_rdata_o shows the entry selected by the current cpu_addr_i in the same cycle, without any buffer stage.
- R6: A cycle with cpu_we_i low changes no entry, whatever cpu_wdata_i and cpu_addr_i carry.
- R7: A write becomes visible only after the rising edge that ends its cycle. A read of the same entry in the write cycle returns the old value on both ports.
- R8: col_idx_o equals the entry selected by pix_idx_i in the same cycle. An index whose bits 1:0 are 00 returns entry 0.
- R9: col_valid_o equals pix_valid_i and pix_ready_o equals col_ready_i. When col_ready_i is low, pix_ready_o is low, so a held pixel is not taken.
- R10: Background index i and sprite index i+16 are separate entries. A write to one leaves the other unchanged (for i not a multiple of 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr_i | input | 14 | Video address pointer; bits 4:0 select the entry |
| cpu_we_i | input | 1 | Write strobe for the current cycle |
| cpu_wdata_i | input | 8 | Write data; bits 7:6 are dropped |
| cpu_rdata_o | output | 8 | Combinational read data; bits 7:6 are zero |
| pix_valid_i | input | 1 | Pixel index valid |
| pix_ready_o | output | 1 | Pixel index accepted when high together with valid |
| pix_idx_i | input | 5 | Pixel palette index: bit 4 selects sprite, bits 1:0 select colour |
| col_valid_o | output | 1 | Colour index valid |
| col_ready_i | input | 1 | Downstream ready |
| col_idx_o | output | 6 | Colour index into the master table |

## Verification
The bench builds the block with its default parameters: 32 entries, groups of four, 6-bit colours, 8-bit data and a 14-bit pointer. A 14-bit pointer lets random addresses hit every one of the 512 mirror copies of the palette window. Thirty-two entries keep the list of alias indices short enough for random traffic to hit entry 0 through each of its aliases many times. Random writes that overlap reads of the same entry in the same cycle exercise the old-value rule on both ports.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned PAL_ENTRIES = 32;
  localparam int unsigned PAL_COLOR_W = 6;
  localparam int unsigned PAL_DATA_W  = 8;
  localparam int unsigned PAL_GROUP   = 4;
  localparam int unsigned VPTR_W      = 14;
endpackage

// File: rtl/pal_addr_fold.sv
module pal_addr_fold #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned GRP_W = 2
) (
  input  logic [IDX_W-1:0] raw_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    if (raw_i[GRP_W-1:0] == '0) idx_o = '0;
    else                         idx_o = raw_i;
  end
endmodule

// File: rtl/pal_entry_bank.sv
module pal_entry_bank #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned GROUP   = 4,
  parameter int unsigned COLOR_W = 6,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [COLOR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   a_idx,
  output logic [COLOR_W-1:0] a_data,
  input  logic [IDX_W-1:0]   b_idx,
  output logic [COLOR_W-1:0] b_data
);
  logic [COLOR_W-1:0] ent_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    if ((i % GROUP) != 0 || i == 0) begin : g_store
      logic [COLOR_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                q <= '0;
        else if (wr_en && wr_idx == IDX_W'(i))     q <= wr_data;
      end
      assign ent_q[i] = q;
    end else begin : g_alias
      assign ent_q[i] = '0;
    end
  end

  assign a_data = ent_q[a_idx];
  assign b_data = ent_q[b_idx];

  // R7: a write is visible after the edge that ends its cycle
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_q[$past(wr_idx)] == $past(wr_data));

  // R6: with no write, the entry seen on port b keeps its value
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ent_q[$past(b_idx)] == $past(b_data));
endmodule

// File: rtl/pal_index_mem.sv
module pal_index_mem
  import pal_pkg::*;
#(
  parameter int unsigned ENTRIES = PAL_ENTRIES,
  parameter int unsigned GROUP   = PAL_GROUP,
  parameter int unsigned COLOR_W = PAL_COLOR_W,
  parameter int unsigned DATA_W  = PAL_DATA_W,
  parameter int unsigned ADDR_W  = VPTR_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned GRP_W  = $clog2(GROUP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              pix_valid_i,
  output logic              pix_ready_o,
  input  logic [IDX_W-1:0]  pix_idx_i,
  output logic              col_valid_o,
  input  logic              col_ready_i,
  output logic [COLOR_W-1:0] col_idx_o
);
  logic [IDX_W-1:0]   cpu_idx, pix_fold;
  logic [COLOR_W-1:0] cpu_col;
  logic               unused_hi;

  assign unused_hi = ^{cpu_addr_i[ADDR_W-1:IDX_W], cpu_wdata_i[DATA_W-1:COLOR_W]};

  pal_addr_fold #(.IDX_W(IDX_W), .GRP_W(GRP_W)) u_fold_cpu (
    .raw_i(cpu_addr_i[IDX_W-1:0]), .idx_o(cpu_idx));

  pal_addr_fold #(.IDX_W(IDX_W), .GRP_W(GRP_W)) u_fold_pix (
    .raw_i(pix_idx_i), .idx_o(pix_fold));

  pal_entry_bank #(.ENTRIES(ENTRIES), .GROUP(GROUP), .COLOR_W(COLOR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cpu_we_i),
    .wr_idx  (cpu_idx),
    .wr_data (cpu_wdata_i[COLOR_W-1:0]),
    .a_idx   (cpu_idx),
    .a_data  (cpu_col),
    .b_idx   (pix_fold),
    .b_data  (col_idx_o)
  );

  assign cpu_rdata_o = {{(DATA_W-COLOR_W){1'b0}}, cpu_col};
  assign col_valid_o = pix_valid_i;
  assign pix_ready_o = col_ready_i;

  // R4: every CPU alias index folds onto entry 0
  a_r4_cpu_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr_i[GRP_W-1:0] == '0) |-> (cpu_idx == '0));

  // R8: pixel aliases fold onto entry 0 as well
  a_r8_pix_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_idx_i[GRP_W-1:0] == '0) |-> (pix_fold == '0));

  // R9: no pixel is taken while downstream stalls
  a_r9_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_i && !col_ready_i) |-> (!pix_ready_o && col_valid_o));

  // R2: top data bits read as zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata_o[DATA_W-1:COLOR_W] == '0);
endmodule

// File: tb/pal_index_mem_tb.sv
`timescale 1ns/1ps
module pal_index_mem_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] cpu_addr_i;
  logic        cpu_we_i;
  logic [7:0]  cpu_wdata_i;
  logic [7:0]  cpu_rdata_o;
  logic        pix_valid_i, pix_ready_o, col_valid_o, col_ready_i;
  logic [4:0]  pix_idx_i;
  logic [5:0]  col_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [5:0] model [32];

  always #5 clk = ~clk;

  pal_index_mem dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr_i(cpu_addr_i), .cpu_we_i(cpu_we_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
    .pix_valid_i(pix_valid_i), .pix_ready_o(pix_ready_o), .pix_idx_i(pix_idx_i),
    .col_valid_o(col_valid_o), .col_ready_i(col_ready_i), .col_idx_o(col_idx_o));

  function automatic int fold(input logic [4:0] a);
    return (a[1:0] == 2'b00) ? 0 : int'(a);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, check combinational outputs, then commit at posedge
  task automatic cyc(input logic [13:0] a, input bit we, input logic [7:0] d,
                     input bit pv, input logic [4:0] pi, input bit cr, input string tag);
    @(negedge clk);
    cpu_addr_i = a; cpu_we_i = we; cpu_wdata_i = d;
    pix_valid_i = pv; pix_idx_i = pi; col_ready_i = cr;
    #1;
    chk(cpu_rdata_o == {2'b00, model[fold(a[4:0])]}, {tag, " R5 cpu read"},
        cpu_rdata_o, {2'b00, model[fold(a[4:0])]});
    chk(col_idx_o == model[fold(pi)], {tag, " R8 render read"}, col_idx_o, model[fold(pi)]);
    chk(col_valid_o == pv && pix_ready_o == cr, {tag, " R9 stream"},
        {col_valid_o, pix_ready_o}, {pv, cr});
    @(posedge clk);
    if (we) model[fold(a[4:0])] = d[5:0];
  endtask

  task automatic rd_expect(input logic [13:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cpu_addr_i = a; cpu_we_i = 1'b0; #1;
    chk(cpu_rdata_o == exp, tag, cpu_rdata_o, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 32; i++) model[i] = '0;
    rst_n = 1'b0; cpu_addr_i = '0; cpu_we_i = 1'b0; cpu_wdata_i = '0;
    pix_valid_i = 1'b0; pix_idx_i = '0; col_ready_i = 1'b1;
    // dirty the state before reset completes is not possible; hold reset
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: all entries read zero after reset on both ports
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      cpu_addr_i = 14'(i); pix_idx_i = 5'(i); #1;
      chk(cpu_rdata_o == 8'h00, "R1 reset cpu", cpu_rdata_o, 0);
      chk(col_idx_o == 6'h00, "R1 reset render", col_idx_o, 0);
    end

    // R2: upper data bits dropped
    cyc(14'h3F03, 1'b1, 8'hFF, 1'b0, 5'd3, 1'b1, "R2");
    rd_expect(14'h0003, 8'h3F, "R2 masked write");

    // R3: mirror above bit 4
    cyc(14'h0027, 1'b1, 8'h15, 1'b0, 5'd0, 1'b1, "R3");
    rd_expect(14'h2AE7, 8'h15, "R3 mirror read");

    // R4: alias write through index 16 hits entry 0; read through 28
    cyc(14'h3F10, 1'b1, 8'h2A, 1'b0, 5'd0, 1'b1, "R4");
    rd_expect(14'h3F00, 8'h2A, "R4 alias write entry0");
    rd_expect(14'h001C, 8'h2A, "R4 alias read 28");

    // R10: background 5 and sprite 21 are distinct
    cyc(14'h0015, 1'b1, 8'h11, 1'b0, 5'd0, 1'b1, "R10a");
    cyc(14'h0005, 1'b1, 8'h22, 1'b0, 5'd0, 1'b1, "R10b");
    rd_expect(14'h0015, 8'h11, "R10 sprite unchanged");

    // R6: strobe low changes nothing
    cyc(14'h0005, 1'b0, 8'h3C, 1'b0, 5'd5, 1'b1, "R6");
    rd_expect(14'h0005, 8'h22, "R6 no write");

    // R7: same-cycle read returns old value, next cycle new (checks inside cyc)
    cyc(14'h0009, 1'b1, 8'h07, 1'b1, 5'd9, 1'b1, "R7 write cycle");
    @(negedge clk); pix_idx_i = 5'd9; cpu_we_i = 1'b0; #1;
    chk(col_idx_o == 6'h07, "R7 render after edge", col_idx_o, 7);

    // R9: back-pressure holds
    cyc(14'h0001, 1'b0, 8'h00, 1'b1, 5'd9, 1'b0, "R9 stall");
    chk(pix_ready_o == 1'b0, "R9 ready low under stall", pix_ready_o, 0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      cyc(14'($urandom), ($urandom % 3) == 0, 8'($urandom), 1'($urandom),
          5'($urandom), 1'($urandom), "rand");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule